// File: doc/BRIEF.md
# Segmented Stream Packet Packer

This block takes packets arriving one 128-bit word per cycle on a narrow ready/valid stream and packs them into a wide output bus. The wide bus is cut into 128-bit segments. Each segment has its own enable, start flag, end flag and empty-byte count, so a packet can close in one segment and the next packet can open in the following segment of the same output beat. No padding is added after each packet end.

The number of live segments is chosen at run time by a 3-bit width selector. Each incoming word lands in exactly one segment, at byte 0, and segments fill in ascending order. A beat is released when every live segment is filled. A partial beat is released when the input goes idle while at least one segment holds data. Both sides use a ready/valid handshake, and backpressure from the wide side stalls the narrow side without losing or repeating any word.

Top module: `seg_stream_packer`

## Requirements
- R1: `cfg_width` selects the live segment count: 0 gives 4, 1 gives 6, 2 gives 8, 3 gives 12, 4 gives 16, and 5 to 7 give 4. The count is capped at `NSEG_MAX`. A segment at or above the live count is never enabled and carries all-zero data and control.
- R2: Each accepted input word occupies one segment. Input byte i appears at bits 8i+7:8i of that segment. When `s_valid` is held high, input word k of a run lands in segment k mod N of output beat k div N, where N is the live count.
- R3: A segment's start flag is set exactly when it holds the first word of a packet. Its end flag is set exactly when it holds the word accepted with `s_last`. Neither flag is set on a disabled segment.
- R4: On an end segment, the 4-bit empty count equals 16 minus the number of set `s_keep` bits. `s_keep` is contiguous from bit 0. The empty count is 0 on segments without the end flag. Bytes whose keep bit was clear appear as zero.
- R5: A new packet always begins at byte 0 of a segment. It may begin in the segment right after the end segment of the previous packet, within the same beat.
- R6: A beat is emitted when all live segments are filled. A beat is also emitted when `s_valid` is low and at least one segment is filled. The enabled segments of a beat are contiguous from segment 0. Unfilled segments have enable low and zero data.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and every output field holds its value.
- R8: `s_ready` is low only while the output is stalled and staging holds a full set of live segments. With `m_ready` held low from reset and `s_valid` held high, exactly 2N words are accepted.
- R9: The sequence of enabled output segments equals the sequence of accepted input words. No word is dropped, duplicated or emitted twice.
- R10: After reset, `m_valid` is low, `s_ready` is high and no segment is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 3 | Live segment count selector |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted when high with `s_valid` |
| s_data | input | 128 | Input word, byte i at bits 8i+7:8i |
| s_keep | input | 16 | Byte enables, contiguous from bit 0 |
| s_last | input | 1 | Word ends a packet |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Output beat accepted when high with `m_valid` |
| m_data | output | NSEG_MAX*128 | Segment s at bits 128s+127:128s |
| m_ena | output | NSEG_MAX | Per-segment enable |
| m_sop | output | NSEG_MAX | Per-segment packet start |
| m_eop | output | NSEG_MAX | Per-segment packet end |
| m_mty | output | NSEG_MAX*4 | Per-segment empty-byte count, segment s at bits 4s+3:4s |

## Verification
The bench builds the packer with the default `NSEG_MAX` of 16. This setting makes all five selector widths reachable, along with the out-of-range selector values that fall back to four segments. With sixteen physical segments, the narrow settings leave unused upper segments, so the zeroing of segments above the live count is exercised. The 2048-bit setting covers the case where every physical segment is live.

// File: rtl/seg_pack_pkg.sv
package seg_pack_pkg;
  localparam int unsigned SEG_BYTES = 16;
  localparam int unsigned SEG_W     = SEG_BYTES * 8;
  localparam int unsigned MTY_W     = $clog2(SEG_BYTES);
  localparam int unsigned SEL_W     = 3;

  // live segment count for a width selector value
  function automatic int unsigned seg_count(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd1:    return 6;
      3'd2:    return 8;
      3'd3:    return 12;
      3'd4:    return 16;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/spk_width_decode.sv
module spk_width_decode
  import seg_pack_pkg::*;
#(
  parameter int unsigned NSEG_MAX = 16,
  parameter int unsigned CNT_W    = 5
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] active
);
  always_comb begin
    int unsigned n;
    n = seg_count(sel);
    if (n > NSEG_MAX) n = NSEG_MAX;
    active = CNT_W'(n);
  end
endmodule

// File: rtl/spk_lane_fmt.sv
module spk_lane_fmt
  import seg_pack_pkg::*;
(
  input  logic [SEG_W-1:0]     in_data,
  input  logic [SEG_BYTES-1:0] in_keep,
  input  logic                 in_last,
  output logic [SEG_W-1:0]     seg_data,
  output logic [MTY_W-1:0]     seg_mty
);
  // clear bytes that are not enabled
  for (genvar b = 0; b < SEG_BYTES; b++) begin : g_byte
    assign seg_data[8*b +: 8] = in_keep[b] ? in_data[8*b +: 8] : 8'h00;
  end

  always_comb begin
    int unsigned n;
    n = 0;
    for (int i = 0; i < SEG_BYTES; i++) n += int'(in_keep[i]);
    seg_mty = in_last ? MTY_W'(SEG_BYTES - n) : '0;
  end
endmodule

// File: rtl/spk_stager.sv
module spk_stager
  import seg_pack_pkg::*;
#(
  parameter int unsigned NSEG  = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [SEG_W-1:0]      wr_data,
  input  logic                  wr_sop,
  input  logic                  wr_eop,
  input  logic [MTY_W-1:0]      wr_mty,
  input  logic                  flush,
  output logic [CNT_W-1:0]      fill,
  output logic [NSEG*SEG_W-1:0] st_data,
  output logic [NSEG-1:0]       st_ena,
  output logic [NSEG-1:0]       st_sop,
  output logic [NSEG-1:0]       st_eop,
  output logic [NSEG*MTY_W-1:0] st_mty
);
  logic [CNT_W-1:0] wr_idx;

  // a flush frees every slot, so the write goes to slot 0
  assign wr_idx = flush ? '0 : fill;

  always_ff @(posedge clk) begin
    if (rst)        fill <= '0;
    else if (flush) fill <= wr_en ? CNT_W'(1) : '0;
    else if (wr_en) fill <= fill + CNT_W'(1);
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG_W-1:0] d_q;
    logic             ena_q, sop_q, eop_q;
    logic [MTY_W-1:0] mty_q;
    logic             hit;

    assign hit = wr_en && (wr_idx == CNT_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        d_q   <= '0;
        ena_q <= 1'b0;
        sop_q <= 1'b0;
        eop_q <= 1'b0;
        mty_q <= '0;
      end else if (hit) begin
        d_q   <= wr_data;
        ena_q <= 1'b1;
        sop_q <= wr_sop;
        eop_q <= wr_eop;
        mty_q <= wr_mty;
      end else if (flush) begin
        d_q   <= '0;
        ena_q <= 1'b0;
        sop_q <= 1'b0;
        eop_q <= 1'b0;
        mty_q <= '0;
      end
    end

    assign st_data[SEG_W*s +: SEG_W] = d_q;
    assign st_ena[s]                 = ena_q;
    assign st_sop[s]                 = sop_q;
    assign st_eop[s]                 = eop_q;
    assign st_mty[MTY_W*s +: MTY_W]  = mty_q;
  end
endmodule

// File: rtl/seg_stream_packer.sv
module seg_stream_packer
  import seg_pack_pkg::*;
#(
  parameter  int unsigned NSEG_MAX = 16,
  localparam int unsigned CNT_W    = $clog2(NSEG_MAX + 1),
  localparam int unsigned BUS_W    = NSEG_MAX * SEG_W,
  localparam int unsigned MTYB_W   = NSEG_MAX * MTY_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     cfg_width,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [SEG_W-1:0]     s_data,
  input  logic [SEG_BYTES-1:0] s_keep,
  input  logic                 s_last,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [BUS_W-1:0]     m_data,
  output logic [NSEG_MAX-1:0]  m_ena,
  output logic [NSEG_MAX-1:0]  m_sop,
  output logic [NSEG_MAX-1:0]  m_eop,
  output logic [MTYB_W-1:0]    m_mty
);
  logic [CNT_W-1:0]    active;
  logic [CNT_W-1:0]    fill;
  logic [SEG_W-1:0]    fmt_data;
  logic [MTY_W-1:0]    fmt_mty;
  logic [BUS_W-1:0]    st_data;
  logic [NSEG_MAX-1:0] st_ena, st_sop, st_eop;
  logic [MTYB_W-1:0]   st_mty;
  logic                in_pkt;
  logic                stage_full, out_free, accept, flush;

  spk_width_decode #(.NSEG_MAX(NSEG_MAX), .CNT_W(CNT_W)) u_dec (
    .sel    (cfg_width),
    .active (active)
  );

  spk_lane_fmt u_fmt (
    .in_data  (s_data),
    .in_keep  (s_keep),
    .in_last  (s_last),
    .seg_data (fmt_data),
    .seg_mty  (fmt_mty)
  );

  // handshake and beat release
  assign stage_full = (fill >= active);
  assign out_free   = !m_valid || m_ready;
  assign s_ready    = !stage_full || out_free;
  assign accept     = s_valid && s_ready;
  assign flush      = out_free && (fill != '0) && (stage_full || !s_valid);

  // packet-start tracking
  always_ff @(posedge clk) begin
    if (rst)         in_pkt <= 1'b0;
    else if (accept) in_pkt <= !s_last;
  end

  spk_stager #(.NSEG(NSEG_MAX), .CNT_W(CNT_W)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (accept),
    .wr_data (fmt_data),
    .wr_sop  (!in_pkt),
    .wr_eop  (s_last),
    .wr_mty  (fmt_mty),
    .flush   (flush),
    .fill    (fill),
    .st_data (st_data),
    .st_ena  (st_ena),
    .st_sop  (st_sop),
    .st_eop  (st_eop),
    .st_mty  (st_mty)
  );

  // registered output beat
  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_ena   <= '0;
      m_sop   <= '0;
      m_eop   <= '0;
      m_mty   <= '0;
    end else if (flush) begin
      m_valid <= 1'b1;
      m_data  <= st_data;
      m_ena   <= st_ena;
      m_sop   <= st_sop;
      m_eop   <= st_eop;
      m_mty   <= st_mty;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spk_checker.sv
module spk_checker
  import seg_pack_pkg::*;
#(
  parameter int unsigned NSEG = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic [SEL_W-1:0]      cfg_width,
  input logic                  s_ready,
  input logic                  m_valid,
  input logic                  m_ready,
  input logic [NSEG*SEG_W-1:0] m_data,
  input logic [NSEG-1:0]       m_ena,
  input logic [NSEG-1:0]       m_sop,
  input logic [NSEG-1:0]       m_eop,
  input logic [NSEG*MTY_W-1:0] m_mty
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> m_valid); // R7

  AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> ($stable(m_data) && $stable(m_ena) && $stable(m_sop)
                               && $stable(m_eop) && $stable(m_mty))); // R7

  AST_READY_STALL: assert property (@(posedge clk) disable iff (rst)
    !s_ready |-> (m_valid && !m_ready)); // R8

  AST_ENA_PACKED: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> ((m_ena != '0) && ((m_ena & (m_ena + 1'b1)) == '0))); // R6

  AST_ENA_LIMIT: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> ($countones(m_ena) <= seg_count(cfg_width))); // R1

  AST_FLAGS_IN_ENA: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (((m_sop | m_eop) & ~m_ena) == '0)); // R3

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    AST_MTY_ZERO: assert property (@(posedge clk) disable iff (rst)
      (m_valid && !m_eop[s]) |-> (m_mty[MTY_W*s +: MTY_W] == '0)); // R4

    AST_IDLE_DATA: assert property (@(posedge clk) disable iff (rst)
      (m_valid && !m_ena[s]) |-> (m_data[SEG_W*s +: SEG_W] == '0)); // R6
  end
endmodule

bind seg_stream_packer spk_checker #(.NSEG(NSEG_MAX)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_width (cfg_width),
  .s_ready   (s_ready),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_data    (m_data),
  .m_ena     (m_ena),
  .m_sop     (m_sop),
  .m_eop     (m_eop),
  .m_mty     (m_mty)
);

// File: tb/test_seg_stream_packer.sv
module test_seg_stream_packer;
  import seg_pack_pkg::*;

  localparam int unsigned NSEG = 16;
  localparam int MAXS = 160;
  localparam int ROWS = 8;
  // columns: selector, live count, base length, length step, packets, ready mode, gap index
  localparam int TBL[ROWS][7] = '{
    '{4, 16, 16,  0, 20, 0, 0},
    '{0,  4,  1,  7, 10, 0, 0},
    '{1,  6, 33,  5,  8, 1, 0},
    '{2,  8, 50,  3,  6, 2, 0},
    '{3, 12, 17, 11,  9, 1, 0},
    '{6,  4, 20,  1,  5, 0, 7},
    '{0,  4, 64,  0, 10, 2, 0},
    '{4, 16, 40,  9,  4, 0, 5}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                  rst = 1'b1;
  logic [2:0]            cfg_width = 3'd0;
  logic                  s_valid = 1'b0, s_ready, s_last = 1'b0;
  logic [SEG_W-1:0]      s_data = '0;
  logic [15:0]           s_keep = '0;
  logic                  m_valid, m_ready = 1'b0;
  logic [NSEG*SEG_W-1:0] m_data;
  logic [NSEG-1:0]       m_ena, m_sop, m_eop;
  logic [NSEG*4-1:0]     m_mty;

  seg_stream_packer #(.NSEG_MAX(NSEG)) i_seg_stream_packer (
    .clk(clk), .rst(rst), .cfg_width(cfg_width),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_keep(s_keep), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_ena(m_ena),
    .m_sop(m_sop), .m_eop(m_eop), .m_mty(m_mty)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [SEG_W-1:0] got, input logic [SEG_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // stimulus and expected segments
  logic [SEG_W-1:0] id[MAXS], ed[MAXS];
  logic [15:0]      ik[MAXS];
  logic [3:0]       em[MAXS];
  bit               il[MAXS], es[MAXS];
  int               nseg, nbeats;
  int               bstart[MAXS], blen[MAXS];
  int               accepted, rcv_beats, rcv_segs, shared;

  task automatic build(input int r);
    int act, gap;
    act = TBL[r][1]; gap = TBL[r][6];
    nseg = 0;
    for (int p = 0; p < TBL[r][4]; p++) begin
      int len, nb;
      len = TBL[r][2] + p * TBL[r][3];
      nb  = (len + 15) / 16;
      for (int b = 0; b < nb; b++) begin
        int v;
        v = len - 16 * b;
        if (v > 16) v = 16;
        for (int i = 0; i < 16; i++) begin
          logic [7:0] by;
          by = 8'(p * 37 + b * 16 + i + 1);
          id[nseg][8*i +: 8] = (i < v) ? by : 8'hFF;
          ed[nseg][8*i +: 8] = (i < v) ? by : 8'h00;
        end
        ik[nseg] = 16'((32'h1 << v) - 1);
        il[nseg] = (b == nb - 1);
        es[nseg] = (b == 0);
        em[nseg] = il[nseg] ? 4'(16 - v) : 4'd0;
        nseg++;
      end
    end
    nbeats = 0;
    for (int st = 0; st < nseg; ) begin
      int en;
      en = st + act;
      if (gap > 0 && st < gap && en > gap) en = gap;
      if (en > nseg) en = nseg;
      bstart[nbeats] = st;
      blen[nbeats]   = en - st;
      nbeats++;
      st = en;
    end
  endtask

  task automatic drive(input int gap);
    for (int k = 0; k < nseg; k++) begin
      bit hs;
      @(negedge clk);
      s_valid = 1'b1; s_data = id[k]; s_keep = ik[k]; s_last = il[k];
      forever begin
        #1 hs = s_ready;
        @(posedge clk);
        if (hs) break;
        @(negedge clk);
      end
      accepted++;
      if (gap > 0 && k == gap - 1) begin
        @(negedge clk);
        s_valid = 1'b0;
        repeat (3) @(negedge clk);
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic monitor(input int mode, input int act, input int r);
    int c;
    bit held;
    logic [NSEG*SEG_W-1:0] snap;
    c = 0; held = 1'b0; snap = '0;
    while (rcv_beats < nbeats) begin
      @(negedge clk);
      if (mode == 2 && c == 30) begin
        chk(accepted == 2 * act, "R8", "words taken under stall", SEG_W'(accepted), SEG_W'(2 * act));
        chk(!s_ready, "R8", "ready under full stall", SEG_W'(s_ready), '0);
      end
      case (mode)
        1:       m_ready = (c % 3 != 2);
        2:       m_ready = (c >= 30);
        default: m_ready = 1'b1;
      endcase
      #2;
      if (held) chk(m_valid && m_data == snap, "R7", "beat held under stall", SEG_W'(m_valid), 1);
      held = m_valid && !m_ready;
      snap = m_data;
      if (m_valid && m_ready) begin
        for (int s = 0; s < NSEG; s++) begin
          int k;
          bit f;
          k = bstart[rcv_beats] + s;
          f = (s < blen[rcv_beats]);
          chk(m_ena[s] == f, (s >= act) ? "R1" : "R6", "segment enable", SEG_W'(m_ena[s]), SEG_W'(f));
          chk(m_data[SEG_W*s +: SEG_W] == (f ? ed[k] : '0), (f && il[k] && em[k] != 0) ? "R4" : "R2",
              "segment data", m_data[SEG_W*s +: SEG_W], f ? ed[k] : '0);
          chk(m_sop[s] == (f && es[k]) && m_eop[s] == (f && il[k]), "R3", "start/end flags",
              SEG_W'({m_sop[s], m_eop[s]}), SEG_W'({f && es[k], f && il[k]}));
          chk(m_mty[4*s +: 4] == (f ? em[k] : 4'd0), "R4", "empty count",
              SEG_W'(m_mty[4*s +: 4]), SEG_W'(f ? em[k] : 4'd0));
          if (f) rcv_segs++;
          if (s < NSEG - 1 && m_ena[s+1] && m_eop[s] && m_sop[s+1]) shared++;
        end
        rcv_beats++;
      end
      c++;
    end
    if (r == 1) chk(shared > 0, "R5", "end and start in one beat", SEG_W'(shared), 1);
  endtask

  task automatic do_reset(input logic [2:0] sel);
    s_valid = 1'b0; m_ready = 1'b0; cfg_width = sel; rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!m_valid, "R10", "valid after reset", SEG_W'(m_valid), '0);
    chk(s_ready, "R10", "ready after reset", SEG_W'(s_ready), 1);
    chk(m_ena == '0, "R10", "enables after reset", SEG_W'(m_ena), '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // table of scenarios
    for (int r = 0; r < ROWS; r++) begin
      do_reset(3'(TBL[r][0]));
      build(r);
      accepted = 0; rcv_beats = 0; rcv_segs = 0; shared = 0;
      fork
        drive(TBL[r][6]);
        monitor(TBL[r][5], TBL[r][1], r);
      join
      repeat (4) begin
        @(negedge clk);
        m_ready = 1'b1;
        #2;
        chk(!m_valid, "R9", "no extra beat", SEG_W'(m_valid), '0);
      end
      chk(rcv_segs == nseg, "R9", "segment total", SEG_W'(rcv_segs), SEG_W'(nseg));
    end

    // directed: reset while a beat is pending under stall
    do_reset(3'd0);
    @(negedge clk);
    s_valid = 1'b1; s_data = '1; s_keep = 16'hFFFF; s_last = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    chk(m_valid, "R6", "full beat pending", SEG_W'(m_valid), 1);
    chk(m_ena == 16'h000F, "R1", "four live segments", SEG_W'(m_ena), SEG_W'(16'h000F));
    rst = 1'b1; s_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!m_valid, "R10", "valid cleared by reset", SEG_W'(m_valid), '0);
    chk(s_ready, "R10", "ready after mid-run reset", SEG_W'(s_ready), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule